// File: doc/BRIEF.md
# Configuration Space Extension Forwarder

This block sits between the configuration request path of a PCIe function and the user application. Each request carries a dword address inside the 4 KB configuration space, four byte enables, a write flag, write data and a function identifier. The identifier is a physical/virtual flag plus an index. Addresses inside two internal windows are served from a local register file. One window sits at the bottom of the PCI-compatible region and the other at the bottom of the extended region. Every other address goes out on an extension bus to the application. The block then returns one completion record per request to the host side.

Reads on the extension bus are limited to one in flight. Incoming requests are stalled while a forwarded read waits. A compile-time cycle limit guards each forwarded read. When the application does not answer in time, the host still gets a successful completion, carrying all-zero data. Forwarded writes are posted: the completion follows at once, without any reply from the application.

The internal register file also holds the headers of the last built-in capability in each region. The next-pointer field of each header is replaced on read by a parameter. Separate parameters exist for the physical and the virtual function, in each region. The same four values are also driven on output pins, so that application logic can link its own capability lists onto them. A second parameter names an alternative intercept interface; enabling it together with this block is rejected at elaboration.

The controller is a six-state machine:
- IDLE: ready for a request.
- INT_ACCESS: register file read or write.
- EXT_WRITE: posted write pulse on the extension bus.
- EXT_READ: read pulse on the extension bus.
- WAIT_DATA: timed wait for the application's read data.
- SEND_CPL: completion held until accepted.

The transitions are:
- IDLE goes to INT_ACCESS on an internal hit, to EXT_WRITE on a forwarded write, and to EXT_READ on a forwarded read.
- INT_ACCESS and EXT_WRITE go to SEND_CPL.
- EXT_READ goes to WAIT_DATA.
- WAIT_DATA goes to SEND_CPL on returned data or on expiry.
- SEND_CPL goes back to IDLE on completion ready.

Top module: `cfg_ext_fwd`

## Requirements
- R1: A read whose dword address is internal returns the stored word. An address is internal if it lies below PCI_INT_DW, or in [64, 64+EXT_INT_DW). The completion is valid in the second cycle after the request is accepted.
- R2: An internal write updates only the bytes whose enable bit is set (bit n covers data bits 8n+7..8n). Its completion carries zero data.
- R3: A read of dword PCI_LAST_CAP_DW shows bits 15:8 as PF_PCI_NEXT for a physical-function request and VF_PCI_NEXT for a virtual-function request (req_vf=1). A read of dword EXT_LAST_CAP_DW shows bits 31:20 as PF_EXT_NEXT or VF_EXT_NEXT in the same way. Writes never change these fields. The four values also drive the pointer output pins.
- R4: A request at a non-internal address produces a one-cycle ext_valid pulse in the cycle after acceptance. The pulse carries the request's write flag, function flag, function index, address, byte enables and write data. Internal hits never raise ext_valid.
- R5: A forwarded write completes in the cycle after its ext_valid pulse, with zero data, whatever the application does.
- R6: A forwarded read completes with ext_rdata if ext_rvalid is high in any of the first TMO_CYCLES cycles after the ext_valid pulse. The completion is valid in the cycle after the data arrives.
- R7: If no data arrives in that window, the completion appears TMO_CYCLES+1 cycles after the ext_valid pulse, with zero data. Every completion's status is Successful Completion, encoded 3'b000.
- R8: req_ready is high only when no request is in progress, so no second request, and therefore no second read, is taken while a forwarded read waits.
- R9: ext_rvalid outside the wait for a forwarded read is ignored: it creates no completion and alters no later result.
- R10: A completion stays valid with unchanged status and data until cpl_ready is high, and req_ready returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vf | input | 1 | 1 = virtual function, 0 = physical function |
| req_fn | input | 8 | Function index |
| req_addr | input | 10 | Dword address in configuration space |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken by the host side |
| cpl_status | output | 3 | Completion status (3'b000 = successful) |
| cpl_data | output | 32 | Completion data (zero for writes) |
| ext_valid | output | 1 | One-cycle request pulse on the extension bus |
| ext_write | output | 1 | Forwarded request is a write |
| ext_vf | output | 1 | Forwarded function flag |
| ext_fn | output | 8 | Forwarded function index |
| ext_addr | output | 10 | Forwarded dword address |
| ext_be | output | 4 | Forwarded byte enables |
| ext_wdata | output | 32 | Forwarded write data |
| ext_rvalid | input | 1 | Application read data valid |
| ext_rdata | input | 32 | Application read data |
| pf_pci_next | output | 8 | PCI-region next pointer, physical function |
| vf_pci_next | output | 8 | PCI-region next pointer, virtual function |
| pf_ext_next | output | 12 | Extended-region next pointer, physical function |
| vf_ext_next | output | 12 | Extended-region next pointer, virtual function |

## Verification
Random requests are split between the two internal windows and the forwarded space. They mix reads, writes and byte-enable patterns, which tests the address decode and the byte-lane write against a model of the register file. Forwarded reads get their data after a random delay. Some delays fall inside the window and some beyond it, so returned data and the zero completion on timeout must each appear in the right cycle. Directed cases cover the boundary cycle on each side of the limit, and writes onto the pointer headers for each function kind. They also cover stray read data after a timeout and completion back-pressure, which separate a correctly ignored late reply from one that corrupts later completions.

// File: rtl/cfg_ext_pkg.sv
package cfg_ext_pkg;

    localparam int DW_ADDR_W    = 10;
    localparam int FN_W         = 8;
    localparam int DATA_W       = 32;
    localparam int BE_W         = DATA_W / 8;
    localparam int PCI_SPACE_DW = 64;
    localparam int STATUS_W     = 3;

    localparam logic [STATUS_W-1:0] CPL_SC = 3'b000;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INT_ACCESS,
        S_EXT_WRITE,
        S_EXT_READ,
        S_WAIT_DATA,
        S_SEND_CPL
    } fwd_state_e;

    typedef struct packed {
        logic                 write;
        logic                 vf;
        logic [FN_W-1:0]      fn;
        logic [DW_ADDR_W-1:0] addr;
        logic [BE_W-1:0]      be;
        logic [DATA_W-1:0]    wdata;
    } cfg_req_t;

endpackage

// File: rtl/cfg_ext_addr_map.sv
module cfg_ext_addr_map
    import cfg_ext_pkg::*;
#(
    parameter int PCI_INT_DW = 16,
    parameter int EXT_INT_DW = 8,
    parameter int IDX_W      = 5
) (
    input  logic [DW_ADDR_W-1:0] addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);

    localparam int EXT_HI_DW = PCI_SPACE_DW + EXT_INT_DW;

    logic in_pci;
    logic in_ext;

    assign in_pci = int'(addr) < PCI_INT_DW;

    if (EXT_INT_DW > 0) begin : g_ext_window
        assign in_ext = (int'(addr) >= PCI_SPACE_DW) && (int'(addr) < EXT_HI_DW);
    end else begin : g_no_ext_window
        assign in_ext = 1'b0;
    end

    assign hit = in_pci || in_ext;

    always_comb begin
        if (in_pci) begin
            idx = IDX_W'(int'(addr));
        end else if (in_ext) begin
            idx = IDX_W'(int'(addr) - PCI_SPACE_DW + PCI_INT_DW);
        end else begin
            idx = '0;
        end
    end

endmodule

// File: rtl/cfg_ext_regfile.sv
module cfg_ext_regfile
    import cfg_ext_pkg::*;
#(
    parameter int         DEPTH       = 24,
    parameter int         IDX_W       = 5,
    parameter int         PCI_PTR_IDX = 13,
    parameter int         EXT_PTR_IDX = 18,
    parameter logic [7:0]  PF_PCI_NEXT = 8'h80,
    parameter logic [7:0]  VF_PCI_NEXT = 8'hA0,
    parameter logic [11:0] PF_EXT_NEXT = 12'h200,
    parameter logic [11:0] VF_EXT_NEXT = 12'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vf,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] raw_word;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    lane_mem[i] <= '0;
                end
            end else if (wr_en && be[b]) begin
                lane_mem[idx] <= wdata[8*b +: 8];
            end
        end

        assign raw_word[8*b +: 8] = lane_mem[idx];
    end

    always_comb begin
        rdata = raw_word;
        if (idx == IDX_W'(PCI_PTR_IDX)) begin
            rdata[15:8] = vf ? VF_PCI_NEXT : PF_PCI_NEXT;
        end
        if (idx == IDX_W'(EXT_PTR_IDX)) begin
            rdata[31:20] = vf ? VF_EXT_NEXT : PF_EXT_NEXT;
        end
    end

    // R2: the controller only writes inside the storage range
    a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(idx) < DEPTH));

endmodule

// File: rtl/cfg_ext_timer.sv
module cfg_ext_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: the wait counter never passes its limit
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= CW'(LIMIT - 1)));

endmodule

// File: rtl/cfg_ext_fwd.sv
module cfg_ext_fwd
    import cfg_ext_pkg::*;
#(
    parameter int          TMO_CYCLES       = 16,
    parameter int          PCI_INT_DW       = 16,
    parameter int          EXT_INT_DW       = 8,
    parameter int          PCI_LAST_CAP_DW  = 13,
    parameter int          EXT_LAST_CAP_DW  = 66,
    parameter logic [7:0]  PF_PCI_NEXT      = 8'h80,
    parameter logic [7:0]  VF_PCI_NEXT      = 8'hA0,
    parameter logic [11:0] PF_EXT_NEXT      = 12'h200,
    parameter logic [11:0] VF_EXT_NEXT      = 12'h300,
    parameter bit          ALT_INTERCEPT_EN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_vf,
    input  logic [FN_W-1:0]      req_fn,
    input  logic [DW_ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]      req_be,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 cpl_valid,
    input  logic                 cpl_ready,
    output logic [STATUS_W-1:0]  cpl_status,
    output logic [DATA_W-1:0]    cpl_data,
    output logic                 ext_valid,
    output logic                 ext_write,
    output logic                 ext_vf,
    output logic [FN_W-1:0]      ext_fn,
    output logic [DW_ADDR_W-1:0] ext_addr,
    output logic [BE_W-1:0]      ext_be,
    output logic [DATA_W-1:0]    ext_wdata,
    input  logic                 ext_rvalid,
    input  logic [DATA_W-1:0]    ext_rdata,
    output logic [7:0]           pf_pci_next,
    output logic [7:0]           vf_pci_next,
    output logic [11:0]          pf_ext_next,
    output logic [11:0]          vf_ext_next
);

    localparam int DEPTH       = PCI_INT_DW + EXT_INT_DW;
    localparam int IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PCI_PTR_IDX = PCI_LAST_CAP_DW;
    localparam int EXT_PTR_IDX = EXT_LAST_CAP_DW - PCI_SPACE_DW + PCI_INT_DW;

    if (ALT_INTERCEPT_EN) begin : g_param_clash
        $error("extension forwarding and the alternative intercept interface cannot both be enabled");
    end
    if (TMO_CYCLES < 1) begin : g_param_tmo
        $error("TMO_CYCLES must be at least 1");
    end

    fwd_state_e        state_q, state_d;
    cfg_req_t          held_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  map_idx;
    logic              map_hit;
    logic [DATA_W-1:0] rf_word;
    logic [DATA_W-1:0] cpl_data_q;
    logic              tmo_hit;
    logic              rf_wr;
    logic              accept;

    cfg_ext_addr_map #(
        .PCI_INT_DW (PCI_INT_DW),
        .EXT_INT_DW (EXT_INT_DW),
        .IDX_W      (IDX_W)
    ) u_map (
        .addr (req_addr),
        .hit  (map_hit),
        .idx  (map_idx)
    );

    assign rf_wr = (state_q == S_INT_ACCESS) && held_q.write;

    cfg_ext_regfile #(
        .DEPTH       (DEPTH),
        .IDX_W       (IDX_W),
        .PCI_PTR_IDX (PCI_PTR_IDX),
        .EXT_PTR_IDX (EXT_PTR_IDX),
        .PF_PCI_NEXT (PF_PCI_NEXT),
        .VF_PCI_NEXT (VF_PCI_NEXT),
        .PF_EXT_NEXT (PF_EXT_NEXT),
        .VF_EXT_NEXT (VF_EXT_NEXT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (rf_wr),
        .idx   (idx_q),
        .be    (held_q.be),
        .wdata (held_q.wdata),
        .vf    (held_q.vf),
        .rdata (rf_word)
    );

    cfg_ext_timer #(
        .LIMIT (TMO_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == S_WAIT_DATA),
        .expired (tmo_hit)
    );

    assign accept = (state_q == S_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (map_hit)        state_d = S_INT_ACCESS;
                    else if (req_write) state_d = S_EXT_WRITE;
                    else                state_d = S_EXT_READ;
                end
            end
            S_INT_ACCESS: state_d = S_SEND_CPL;
            S_EXT_WRITE:  state_d = S_SEND_CPL;
            S_EXT_READ:   state_d = S_WAIT_DATA;
            S_WAIT_DATA: begin
                if (ext_rvalid || tmo_hit) state_d = S_SEND_CPL;
            end
            S_SEND_CPL: begin
                if (cpl_ready) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and completion data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q     <= '0;
            idx_q      <= '0;
            cpl_data_q <= '0;
        end else begin
            if (accept) begin
                held_q <= '{write: req_write, vf: req_vf, fn: req_fn, addr: req_addr,
                            be: req_be, wdata: req_wdata};
                idx_q  <= map_idx;
            end
            unique case (state_q)
                S_INT_ACCESS: cpl_data_q <= held_q.write ? '0 : rf_word;
                S_EXT_WRITE:  cpl_data_q <= '0;
                S_WAIT_DATA: begin
                    if (ext_rvalid)   cpl_data_q <= ext_rdata;
                    else if (tmo_hit) cpl_data_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        cpl_valid = 1'b0;
        ext_valid = 1'b0;
        unique case (state_q)
            S_IDLE:      req_ready = 1'b1;
            S_EXT_WRITE: ext_valid = 1'b1;
            S_EXT_READ:  ext_valid = 1'b1;
            S_SEND_CPL:  cpl_valid = 1'b1;
            default: ;
        endcase
    end

    assign cpl_status  = CPL_SC;
    assign cpl_data    = cpl_data_q;
    assign ext_write   = held_q.write;
    assign ext_vf      = held_q.vf;
    assign ext_fn      = held_q.fn;
    assign ext_addr    = held_q.addr;
    assign ext_be      = held_q.be;
    assign ext_wdata   = held_q.wdata;
    assign pf_pci_next = PF_PCI_NEXT;
    assign vf_pci_next = VF_PCI_NEXT;
    assign pf_ext_next = PF_EXT_NEXT;
    assign vf_ext_next = VF_EXT_NEXT;

    // R4: each forwarded request is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |=> !ext_valid);

    // R5: a posted write completes right after its pulse
    a_r5_posted_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && ext_write) |=> (cpl_valid && cpl_data == '0));

    // R6: data returned in the window reaches the completion
    a_r6_data_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_DATA && ext_rvalid) |=> (cpl_valid && cpl_data == $past(ext_rdata)));

    // R7: expiry yields a zero completion
    a_r7_zero_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_hit && !ext_rvalid) |=> (cpl_valid && cpl_data == '0));

    // R8: after a read pulse no request is taken and no new pulse goes out
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && !ext_write) |=> (!req_ready && !ext_valid));

    // R9: stray read data leaves the completion data untouched
    a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rvalid && (state_q == S_IDLE || state_q == S_SEND_CPL)) |=> $stable(cpl_data));

    // R10: a stalled completion is held unchanged
    a_r10_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_data) && $stable(cpl_status)));

endmodule

// File: tb/cfg_ext_fwd_bench.sv
module cfg_ext_fwd_bench;

    localparam int          TMO          = 16;
    localparam int          PCI_INT      = 16;
    localparam int          EXT_INT      = 8;
    localparam int          PCI_LAST     = 13;
    localparam int          EXT_LAST     = 66;
    localparam logic [7:0]  PF_PCI       = 8'h80;
    localparam logic [7:0]  VF_PCI       = 8'hA0;
    localparam logic [11:0] PF_EXT       = 12'h200;
    localparam logic [11:0] VF_EXT       = 12'h300;
    localparam int          DEPTH        = PCI_INT + EXT_INT;
    localparam int          N_RANDOM     = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_vf = 1'b0;
    logic [7:0]  req_fn = '0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [2:0]  cpl_status;
    logic [31:0] cpl_data;
    logic        ext_valid, ext_write, ext_vf;
    logic [7:0]  ext_fn;
    logic [9:0]  ext_addr;
    logic [3:0]  ext_be;
    logic [31:0] ext_wdata;
    logic        ext_rvalid = 1'b0;
    logic [31:0] ext_rdata = '0;
    logic [7:0]  pf_pci_next, vf_pci_next;
    logic [11:0] pf_ext_next, vf_ext_next;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [31:0] model [DEPTH];

    always #5 clk = ~clk;

    cfg_ext_fwd #(
        .TMO_CYCLES (TMO), .PCI_INT_DW (PCI_INT), .EXT_INT_DW (EXT_INT),
        .PCI_LAST_CAP_DW (PCI_LAST), .EXT_LAST_CAP_DW (EXT_LAST),
        .PF_PCI_NEXT (PF_PCI), .VF_PCI_NEXT (VF_PCI),
        .PF_EXT_NEXT (PF_EXT), .VF_EXT_NEXT (VF_EXT), .ALT_INTERCEPT_EN (1'b0)
    ) u_cfg_ext_fwd (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_vf (req_vf), .req_fn (req_fn), .req_addr (req_addr), .req_be (req_be),
        .req_wdata (req_wdata),
        .cpl_valid (cpl_valid), .cpl_ready (cpl_ready), .cpl_status (cpl_status),
        .cpl_data (cpl_data),
        .ext_valid (ext_valid), .ext_write (ext_write), .ext_vf (ext_vf),
        .ext_fn (ext_fn), .ext_addr (ext_addr), .ext_be (ext_be), .ext_wdata (ext_wdata),
        .ext_rvalid (ext_rvalid), .ext_rdata (ext_rdata),
        .pf_pci_next (pf_pci_next), .vf_pci_next (vf_pci_next),
        .pf_ext_next (pf_ext_next), .vf_ext_next (vf_ext_next)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_int(input logic [9:0] a);
        return (int'(a) < PCI_INT) || (int'(a) >= 64 && int'(a) < 64 + EXT_INT);
    endfunction

    function automatic int midx(input logic [9:0] a);
        return (int'(a) < PCI_INT) ? int'(a) : int'(a) - 64 + PCI_INT;
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a, input bit vf);
        logic [31:0] w;
        w = model[midx(a)];
        if (int'(a) == PCI_LAST) w[15:8] = vf ? VF_PCI : PF_PCI;
        if (int'(a) == EXT_LAST) w[31:20] = vf ? VF_EXT : PF_EXT;
        return w;
    endfunction

    function automatic logic [31:0] merge_be(input logic [31:0] old, input logic [31:0] nw,
                                             input logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // k: wait cycle in which read data is returned; k >= TMO means no reply in time
    task automatic run_txn(input bit wr, input bit vf, input logic [7:0] fn,
                           input logic [9:0] a, input logic [3:0] be, input logic [31:0] wd,
                           input int k, input logic [31:0] rd, input int hold,
                           input bit stray);
        logic [31:0] exp_data;
        bit internal;
        int guard;
        internal = is_int(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vf = vf; req_fn = fn;
        req_addr = a; req_be = be; req_wdata = wd;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "ready low after accept", 32'(req_ready), 32'd0);
        if (internal) begin
            chk("R4", "no forward on internal hit", 32'(ext_valid), 32'd0);
            exp_data = wr ? 32'd0 : exp_read(a, vf);
            if (wr) model[midx(a)] = merge_be(model[midx(a)], wd, be);
            @(negedge clk);
            chk(wr ? "R2" : "R1", "internal cpl valid", 32'(cpl_valid), 32'd1);
        end else begin
            chk("R4", "ext_valid", 32'(ext_valid), 32'd1);
            chk("R4", "ext_write", 32'(ext_write), 32'(wr));
            chk("R4", "ext_vf", 32'(ext_vf), 32'(vf));
            chk("R4", "ext_fn", 32'(ext_fn), 32'(fn));
            chk("R4", "ext_addr", 32'(ext_addr), 32'(a));
            chk("R4", "ext_be", 32'(ext_be), 32'(be));
            chk("R4", "ext_wdata", ext_wdata, wd);
            if (wr) begin
                exp_data = 32'd0;
                @(negedge clk);
                chk("R5", "posted write cpl valid", 32'(cpl_valid), 32'd1);
            end else if (k < TMO) begin
                exp_data = rd;
                repeat (k + 1) @(negedge clk);
                chk("R8", "ready low while waiting", 32'(req_ready), 32'd0);
                chk("R8", "no second pulse", 32'(ext_valid), 32'd0);
                ext_rvalid = 1'b1; ext_rdata = rd;
                @(negedge clk);
                ext_rvalid = 1'b0;
                chk("R6", "cpl after data", 32'(cpl_valid), 32'd1);
            end else begin
                exp_data = 32'd0;
                repeat (TMO) @(negedge clk);
                chk("R7", "no cpl before expiry", 32'(cpl_valid), 32'd0);
                @(negedge clk);
                chk("R7", "cpl at expiry", 32'(cpl_valid), 32'd1);
            end
        end
        chk("R7", "status successful", 32'(cpl_status), 32'd0);
        chk(internal ? (wr ? "R2" : "R1") : (wr ? "R5" : (k < TMO ? "R6" : "R7")),
            "cpl data", cpl_data, exp_data);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R10", "held valid", 32'(cpl_valid), 32'd1);
            chk("R10", "held data", cpl_data, exp_data);
        end
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
        chk("R10", "cpl dropped after accept", 32'(cpl_valid), 32'd0);
        chk("R10", "ready back", 32'(req_ready), 32'd1);
        if (stray) begin
            ext_rvalid = 1'b1; ext_rdata = 32'hDEAD_BEEF;
            @(negedge clk);
            ext_rvalid = 1'b0;
            chk("R9", "no cpl from stray data", 32'(cpl_valid), 32'd0);
            @(negedge clk);
            chk("R9", "still idle", 32'(cpl_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241104));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset ready", 32'(req_ready), 32'd1);
        chk("R10", "reset cpl_valid", 32'(cpl_valid), 32'd0);
        chk("R4", "reset ext_valid", 32'(ext_valid), 32'd0);
        chk("R3", "pf_pci_next pin", 32'(pf_pci_next), 32'(PF_PCI));
        chk("R3", "vf_pci_next pin", 32'(vf_pci_next), 32'(VF_PCI));
        chk("R3", "pf_ext_next pin", 32'(pf_ext_next), 32'(PF_EXT));
        chk("R3", "vf_ext_next pin", 32'(vf_ext_next), 32'(VF_EXT));

        // R3: pointer headers per function kind, and read-only after a full write
        run_txn(1'b0, 1'b0, 8'd0, 10'(PCI_LAST), 4'hF, '0, 0, '0, 0, 1'b0);
        run_txn(1'b0, 1'b1, 8'd3, 10'(PCI_LAST), 4'hF, '0, 0, '0, 0, 1'b0);
        run_txn(1'b1, 1'b0, 8'd0, 10'(PCI_LAST), 4'hF, 32'hFFFF_FFFF, 0, '0, 0, 1'b0);
        run_txn(1'b0, 1'b1, 8'd1, 10'(PCI_LAST), 4'hF, '0, 0, '0, 0, 1'b0);
        run_txn(1'b1, 1'b1, 8'd2, 10'(EXT_LAST), 4'hF, 32'hFFFF_FFFF, 0, '0, 0, 1'b0);
        run_txn(1'b0, 1'b0, 8'd0, 10'(EXT_LAST), 4'hF, '0, 0, '0, 0, 1'b0);
        run_txn(1'b0, 1'b1, 8'd2, 10'(EXT_LAST), 4'hF, '0, 0, '0, 0, 1'b0);
        // R2: partial byte enables
        run_txn(1'b1, 1'b0, 8'd0, 10'd4, 4'b0101, 32'h1122_3344, 0, '0, 0, 1'b0);
        run_txn(1'b0, 1'b0, 8'd0, 10'd4, 4'hF, '0, 0, '0, 1, 1'b0);
        // R6/R7: both sides of the window edge, plus late stray data (R9)
        run_txn(1'b0, 1'b0, 8'd5, 10'd200, 4'hF, '0, 0, 32'hCAFE_0001, 0, 1'b0);
        run_txn(1'b0, 1'b1, 8'd6, 10'd201, 4'hF, '0, TMO - 1, 32'hCAFE_0002, 2, 1'b0);
        run_txn(1'b0, 1'b0, 8'd7, 10'd40, 4'hF, '0, TMO, 32'hCAFE_0003, 0, 1'b1);
        run_txn(1'b1, 1'b0, 8'd8, 10'd72, 4'h3, 32'h5555_AAAA, 0, '0, 1, 1'b1);

        for (int n = 0; n < N_RANDOM; n++) begin
            logic [9:0] a;
            int kind;
            int k;
            kind = $urandom_range(0, 2);
            if (kind == 0)      a = 10'($urandom_range(0, PCI_INT - 1));
            else if (kind == 1) a = 10'($urandom_range(64, 64 + EXT_INT - 1));
            else begin
                a = 10'($urandom_range(0, 1023));
                while (is_int(a)) a = 10'($urandom_range(0, 1023));
            end
            k = $urandom_range(0, TMO + 3);
            run_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    8'($urandom_range(0, 255)), a, 4'($urandom_range(1, 15)),
                    $urandom(), k, $urandom(), $urandom_range(0, 2),
                    (k >= TMO) ? 1'b1 : 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule